// File: doc/BRIEF.md
# Hash command and context-switch controller

This block sequences a block-oriented SHA-256/HMAC compression engine on behalf of a CPU. Software writes a four-bit command word. Each set bit acts as a one-shot trigger for one of four operations: begin a new hash, finalize the current one, suspend after the block in flight, and resume a suspended hash. The controller hands each available message block to the engine. It keeps the running digest and the 64-bit message bit count, and it raises a sticky done interrupt when a suspension or a finalization has completed.

The working state for the first block comes from one of two places. A fresh hash seeds the engine with the standard initial vector and a bit count of zero. A resumed hash instead takes the eight digest words and the bit count that software wrote back into the context window. Between the two, software can read that context window, store the digest and length, run other work on the engine, and return later. The compression rounds, the padding arithmetic and the message buffer lie outside this block. The engine is reached through a start pulse and a completion pulse.

Top module: `hash_ctrl`

## Requirements
- R1: A command write (`cmd_we` high) triggers start with bit 0, process with bit 1, stop with bit 2 and continue with bit 3. When several bits are set, start takes priority, then continue, then process, then stop. A write with all four bits zero has no effect.
- R2: Start is accepted only from idle. It clears the bit count to zero, and the first engine pass after it is seeded with the initial vector.
- R3: Each completed message block adds 512 to the bit count and replaces the digest with the engine result. Every pass after the first is seeded with the current digest.
- R4: Process, accepted while waiting for a block or while a block is hashing, runs a single final pass once any block in flight has completed. That pass has `eng_final` high and `eng_len` equal to the bit count. When it completes, the digest takes the result, done is set and the controller returns to idle.
- R5: Stop written while a block is hashing lets that block complete and then sets done and returns to idle, with no final pass. The digest and the bit count are left readable.
- R6: Stop written while idle, or while waiting with no block in progress, sets done on the next cycle and leaves the controller idle. Stop during a final pass has no effect.
- R7: Continue, accepted only from idle, resumes with the restored digest as the seed of the next pass and the restored bit count as `eng_len`.
- R8: Context address 0 to 7 reads digest word 0 to 7, address 8 reads the low 32 bits of the bit count, address 9 reads the high 32 bits, and every other address reads zero. Context writes are accepted only while idle and are otherwise ignored.
- R9: Start or continue while not idle, and process while idle or during a final pass, are ignored and set the sticky `cmd_err`.
- R10: `done_irq` and `cmd_err` stay set until `done_clr` or `err_clr` respectively is pulsed. A new set in the same cycle as a clear wins.
- R11: `eng_start` is a single-cycle pulse, issued once per block or final pass and only while that pass is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 4 | Command bits: start, process, stop, continue |
| ctx_we | input | 1 | Context word write strobe |
| ctx_addr | input | 4 | Context word address (read and write) |
| ctx_wdata | input | 32 | Context write data |
| ctx_rdata | output | 32 | Context read data for `ctx_addr` |
| blk_valid | input | 1 | A full message block is ready for the engine |
| eng_start | output | 1 | Pulse launching one engine pass |
| eng_final | output | 1 | The pass being launched is the finalization |
| eng_seed | output | 256 | Working hash state given to the engine |
| eng_len | output | 64 | Running message bit count given to the engine |
| eng_done | input | 1 | Engine pass completed |
| eng_result | input | 256 | Engine output state |
| done_irq | output | 1 | Sticky completion interrupt |
| done_clr | input | 1 | Clears `done_irq` |
| cmd_err | output | 1 | Sticky illegal-command flag |
| err_clr | input | 1 | Clears `cmd_err` |

## Verification
The case that is hardest to reach is a stop that arrives while a block is inside the engine. The later resume must then take its seed and bit count from values that software wrote back, not from the controller's own history. The bench reaches it by raising a block, waiting for the launch pulse, and issuing stop inside the fixed engine latency. It then writes back a deliberately altered digest and a bit count with a non-zero upper word before continuing. It sweeps every split point of a three-block message this way, so any stale state shows up as a wrong seed at the next launch or a wrong final digest.

// File: rtl/hash_ctrl.sv
module hash_ctrl #(
  parameter int WORD_W   = 32,
  parameter int WORDS    = 8,
  parameter int BLK_BITS = 512,
  parameter logic [WORDS*WORD_W-1:0] IV = {
    32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
    32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_we,
  input  logic [3:0]              cmd_wdata,
  input  logic                    ctx_we,
  input  logic [3:0]              ctx_addr,
  input  logic [WORD_W-1:0]       ctx_wdata,
  output logic [WORD_W-1:0]       ctx_rdata,
  input  logic                    blk_valid,
  output logic                    eng_start,
  output logic                    eng_final,
  output logic [WORDS*WORD_W-1:0] eng_seed,
  output logic [2*WORD_W-1:0]     eng_len,
  input  logic                    eng_done,
  input  logic [WORDS*WORD_W-1:0] eng_result,
  output logic                    done_irq,
  input  logic                    done_clr,
  output logic                    cmd_err,
  input  logic                    err_clr
);
  localparam int SW    = WORDS * WORD_W;
  localparam int LEN_W = 2 * WORD_W;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HASH, S_FIN} st_t;

  st_t              st;
  logic [SW-1:0]    dig;
  logic [LEN_W-1:0] len;
  logic             first, stop_p, proc_p;

  wire c_start = cmd_we & cmd_wdata[0];
  wire c_proc  = cmd_we & cmd_wdata[1];
  wire c_stop  = cmd_we & cmd_wdata[2];
  wire c_cont  = cmd_we & cmd_wdata[3];
  wire c_any   = cmd_we & (|cmd_wdata);
  wire idle    = (st == S_IDLE);

  assign eng_final = (st == S_FIN);
  assign eng_seed  = first ? IV : dig;
  assign eng_len   = len;

  always_comb begin
    ctx_rdata = '0;
    if (int'(ctx_addr) < WORDS)        ctx_rdata = dig[int'(ctx_addr)*WORD_W +: WORD_W];
    else if (int'(ctx_addr) == WORDS)  ctx_rdata = len[WORD_W-1:0];
    else if (int'(ctx_addr) == WORDS+1) ctx_rdata = len[LEN_W-1:WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      dig <= '0;
      len <= '0;
      first <= 1'b0;
      stop_p <= 1'b0;
      proc_p <= 1'b0;
      eng_start <= 1'b0;
      done_irq <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      if (done_clr) done_irq <= 1'b0;
      if (err_clr)  cmd_err  <= 1'b0;

      if (ctx_we && idle) begin
        if (int'(ctx_addr) < WORDS)         dig[int'(ctx_addr)*WORD_W +: WORD_W] <= ctx_wdata;
        else if (int'(ctx_addr) == WORDS)   len[WORD_W-1:0] <= ctx_wdata;
        else if (int'(ctx_addr) == WORDS+1) len[LEN_W-1:WORD_W] <= ctx_wdata;
      end

      case (st)
        S_WAIT: if (!c_any) begin
          if (stop_p) begin
            st <= S_IDLE; done_irq <= 1'b1; stop_p <= 1'b0;
          end else if (proc_p) begin
            st <= S_FIN; eng_start <= 1'b1; proc_p <= 1'b0;
          end else if (blk_valid) begin
            st <= S_HASH; eng_start <= 1'b1;
          end
        end
        S_HASH: if (eng_done) begin
          dig <= eng_result;
          len <= len + LEN_W'(BLK_BITS);
          first <= 1'b0;
          if (stop_p) begin
            st <= S_IDLE; done_irq <= 1'b1; stop_p <= 1'b0; proc_p <= 1'b0;
          end else st <= S_WAIT;
        end
        S_FIN: if (eng_done) begin
          dig <= eng_result;
          st <= S_IDLE;
          done_irq <= 1'b1;
        end
        default: ;
      endcase

      if (c_start) begin
        if (idle) begin
          st <= S_WAIT; first <= 1'b1; len <= '0; stop_p <= 1'b0; proc_p <= 1'b0;
        end else cmd_err <= 1'b1;
      end else if (c_cont) begin
        if (idle) begin
          st <= S_WAIT; first <= 1'b0; stop_p <= 1'b0; proc_p <= 1'b0;
        end else cmd_err <= 1'b1;
      end else if (c_proc) begin
        if (st == S_WAIT || st == S_HASH) proc_p <= 1'b1;
        else cmd_err <= 1'b1;
      end else if (c_stop) begin
        if (st == S_IDLE || st == S_WAIT) begin
          st <= S_IDLE; done_irq <= 1'b1; stop_p <= 1'b0; proc_p <= 1'b0;
        end else if (st == S_HASH) stop_p <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hash_ctrl_chk.sv
module hash_ctrl_chk #(
  parameter int LEN_W    = 64,
  parameter int BLK_BITS = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic [3:0]       cmd_wdata,
  input logic             eng_start,
  input logic             eng_done,
  input logic             done_irq,
  input logic             done_clr,
  input logic             cmd_err,
  input logic             err_clr,
  input logic [1:0]       st,
  input logic [LEN_W-1:0] len
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R11
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (st == 2'd2 || st == 2'd3)); // R11
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq && !done_clr |=> done_irq); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err && !err_clr |=> cmd_err); // R10
  AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && st == 2'd2 |=> len == $past(len) + LEN_W'(BLK_BITS)); // R3
  AST_IDLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata == 4'b0100 && st == 2'd0 |=> done_irq && st == 2'd0); // R6
  AST_FINAL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && st == 2'd3 |=> done_irq && st == 2'd0); // R4
endmodule

bind hash_ctrl hash_ctrl_chk #(.LEN_W(LEN_W), .BLK_BITS(BLK_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
  .eng_start(eng_start), .eng_done(eng_done), .done_irq(done_irq),
  .done_clr(done_clr), .cmd_err(cmd_err), .err_clr(err_clr),
  .st(st), .len(len));

// File: tb/tb_hash_ctrl.sv
`timescale 1ns/1ps
module tb_hash_ctrl;
  localparam int LAT = 3;
  localparam logic [255:0] IVB = {
    32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
    32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667};

  logic clk = 0, rst_n = 0;
  logic cmd_we = 0; logic [3:0] cmd_wdata = 0;
  logic ctx_we = 0; logic [3:0] ctx_addr = 0; logic [31:0] ctx_wdata = 0;
  logic [31:0] ctx_rdata;
  logic blk_valid = 0, eng_start, eng_final, eng_done = 0;
  logic [255:0] eng_seed, eng_result = 0;
  logic [63:0] eng_len;
  logic done_irq, done_clr = 0, cmd_err, err_clr = 0;

  always #5 clk = ~clk;

  hash_ctrl dut (.*);

  int n_chk = 0, n_bad = 0, starts = 0, finals = 0;
  logic [255:0] e_dig = 0;
  logic [63:0]  e_len = 0;
  logic         e_first = 0;
  bit           over = 0;

  function automatic logic [255:0] engf(input logic [255:0] s, input logic fin, input logic [63:0] l);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = s[i*32 +: 32] * 32'd5 + 32'h9e3779b9 + 32'(i);
      if (fin) w = w ^ l[31:0] ^ l[63:32];
      r[i*32 +: 32] = w;
    end
    return r;
  endfunction

  // engine model: fixed latency, updates at posedge+1
  initial begin
    int cnt;
    logic [255:0] s; logic f; logic [63:0] l;
    cnt = 0;
    forever begin
      @(posedge clk); #1;
      eng_done = 0;
      if (eng_start) begin
        s = eng_seed; f = eng_final; l = eng_len; cnt = LAT;
        starts++; if (eng_final) finals++;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin eng_done = 1; eng_result = engf(s, f, l); end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] b);
    @(negedge clk); cmd_we = 1; cmd_wdata = b;
    @(negedge clk); cmd_we = 0; cmd_wdata = 0;
  endtask

  task automatic ctxw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); ctx_we = 1; ctx_addr = a; ctx_wdata = d;
    @(negedge clk); ctx_we = 0;
  endtask

  task automatic clr_done();
    @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0;
    chk("R10 done cleared", 64'(done_irq), 0);
  endtask

  task automatic chk_ctx(input string req);
    for (int a = 0; a < 16; a++) begin
      logic [31:0] e;
      ctx_addr = 4'(a); #1;
      if (a < 8) e = e_dig[a*32 +: 32];
      else if (a == 8) e = e_len[31:0];
      else if (a == 9) e = e_len[63:32];
      else e = 0;
      chk(req, 64'(ctx_rdata), 64'(e));
    end
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!eng_start);
  endtask

  task automatic wait_eng();
    do @(negedge clk); while (!eng_done);
    @(negedge clk);
  endtask

  task automatic seed_chk(input string req, input logic fin);
    chk(req, 64'(eng_seed == (e_first ? IVB : e_dig)), 1);
    chk(req, eng_len, e_len);
    chk(req, 64'(eng_final), 64'(fin));
  endtask

  task automatic feed(input bit stop_mid);
    @(negedge clk); blk_valid = 1;
    wait_start();
    seed_chk(e_first ? "R2 first seed" : "R3 chained seed", 0);
    blk_valid = 0;
    e_dig = engf(e_first ? IVB : e_dig, 0, e_len);
    e_len += 512; e_first = 0;
    if (stop_mid) cmd(4'b0100);
    wait_eng();
  endtask

  task automatic finalize();
    cmd(4'b0010);
    wait_start();
    seed_chk("R4 final pass", 1);
    e_dig = engf(e_first ? IVB : e_dig, 1, e_len);
    wait_eng();
    chk("R4 done after final", 64'(done_irq), 1);
    chk_ctx("R4 digest after final");
    clr_done();
  endtask

  task automatic start_op();
    cmd(4'b0001); e_first = 1; e_len = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!over) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s0, f0;
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R10 reset done", 64'(done_irq), 0);
    chk("R10 reset err", 64'(cmd_err), 0);
    chk("R11 reset start", 64'(eng_start), 0);
    chk_ctx("R8 reset context");

    // plain hashes of 0..3 blocks
    for (int n = 0; n < 4; n++) begin
      start_op();
      for (int b = 0; b < n; b++) feed(0);
      chk_ctx("R3 context after blocks");
      finalize();
    end

    // process issued while a block is hashing
    start_op();
    @(negedge clk); blk_valid = 1; wait_start(); blk_valid = 0;
    seed_chk("R2 first seed", 0);
    e_dig = engf(IVB, 0, 0); e_len = 512; e_first = 0;
    finalize();

    // stop mid-block, restore altered context, continue
    for (int k = 1; k < 3; k++) begin
      start_op();
      for (int b = 0; b < k - 1; b++) feed(0);
      f0 = finals;
      feed(1);
      chk("R5 done after stop", 64'(done_irq), 1);
      chk("R5 no final pass", 64'(finals), 64'(f0));
      chk_ctx("R5 saved context");
      clr_done();
      for (int a = 0; a < 8; a++) begin
        logic [31:0] w;
        w = e_dig[a*32 +: 32] ^ (32'h0f0f0000 + 32'(a * k));
        ctxw(4'(a), w); e_dig[a*32 +: 32] = w;
      end
      e_len = e_len + {32'(k), 32'h0};
      ctxw(4'd8, e_len[31:0]); ctxw(4'd9, e_len[63:32]);
      chk_ctx("R8 restored context");
      cmd(4'b1000); e_first = 0;
      chk("R7 continue accepted", 64'(cmd_err), 0);
      for (int b = k; b < 3; b++) feed(0);
      finalize();
    end

    // stop while waiting with no block, and while idle
    start_op(); s0 = starts;
    cmd(4'b0100);
    chk("R6 stop in wait done next cycle", 64'(done_irq), 1);
    @(negedge clk); blk_valid = 1; repeat (3) @(negedge clk); blk_valid = 0;
    chk("R6 idle after stop no launch", 64'(starts), 64'(s0));
    clr_done();
    cmd(4'b0100);
    chk("R6 stop in idle done", 64'(done_irq), 1);
    clr_done();

    // illegal commands and ignored writes
    cmd(4'b0010);
    chk("R9 process in idle err", 64'(cmd_err), 1);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    chk("R10 err cleared", 64'(cmd_err), 0);
    start_op();
    feed(0);
    cmd(4'b0001);
    chk("R9 start busy err", 64'(cmd_err), 1);
    chk_ctx("R9 start busy ignored");
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    cmd(4'b1000);
    chk("R9 continue busy err", 64'(cmd_err), 1);
    ctxw(4'd8, 32'hdead_beef);
    chk_ctx("R8 busy write ignored");
    s0 = starts;
    cmd(4'b0000); repeat (3) @(negedge clk);
    chk("R1 zero write no launch", 64'(starts), 64'(s0));
    chk("R1 zero write no done", 64'(done_irq), 0);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    cmd(4'b0110);
    chk("R1 process beats stop", 64'(done_irq), 0);
    wait_start();
    seed_chk("R1 final after combined write", 1);
    e_dig = engf(e_dig, 1, e_len);
    wait_eng();
    chk("R4 done", 64'(done_irq), 1);
    chk_ctx("R4 digest");
    clr_done();

    over = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule